// File: doc/BRIEF.md
# UART Receive Error and Break Monitor

This block receives asynchronous serial characters and tracks their errors. A bit-time tick from an external baud generator marks the moments when the line is sampled. Every received character is checked for parity and stop-bit errors. It is then stored either in a single holding register or, when FIFO mode is selected, in a 16-entry receive FIFO. In the FIFO, each entry keeps its own framing and parity error bits next to the data.

Sticky global flags record framing, parity, overrun, FIFO overflow and line break. A combined error flag is the OR of the break, framing, parity and overrun flags. Break is declared only when the line stays low for ten further bit times after the framing error of the low frame. A software reset during that window cancels the break. The software reset clears the global flags and restarts the receiver. It leaves the stored words and their per-word error bits in place, and only the system reset removes those.

Top module: `uart_rx_errmon`

## Requirements
- R1: A frame is a start bit, 8 data bits least significant bit first, an optional parity bit and a stop bit, each sampled on a clock edge where `bit_tick` is high. A start bit is recognised only when a low sample directly follows a high sample. The word can be read on the clock after the stop sample.
- R2: When `par_en` is 1, the parity bit follows the data. With `par_odd`=0 the data and parity together hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `perr` and the word's parity bit, `rd_data[14]`.
- R3: A low stop sample sets `ferr` and the word's framing bit, `rd_data[15]`, and the word is still stored.
- R4: After a framing error, `brk` rises on the tenth further consecutive low sample. A high sample before that returns the receiver to idle with no break. While `brk` is set, no new frame is received.
- R5: `sw_rst` clears `ferr`, `perr`, `oerr`, `brk`, `ffovf` and the receive state. A break window in progress is abandoned and `brk` does not rise for that low period. A new start bit is accepted only after the line has been sampled high again.
- R6: `rx_err` is high exactly when any of `brk`, `ferr`, `oerr` or `perr` is high.
- R7: In FIFO mode (`fifo_en`=1), words queue in order, up to 16 of them. `rd_data` shows the oldest word as {framing bit, parity bit, six zeros, data}. `rd` removes it, and `rx_avail` shows that the FIFO is not empty.
- R8: Stored words and their per-word error bits are unchanged by `sw_rst`.
- R9: A word that arrives while the FIFO holds 16 words is discarded and sets `ffovf`. The stored words are kept, and `clr_ovf` clears `ffovf`.
- R10: In non-FIFO mode, `rd_data` is {8 zeros, data} from a single holding register. A word that arrives while the register is still unread sets `oerr` and is discarded. `ferr` and `perr` are set in both modes.
- R11: `irq` equals (`err_ie` AND `rx_err`) OR (`brk_ie` AND `brk`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset, synchronous, one or more cycles |
| rx | input | 1 | Serial receive line, idle high |
| bit_tick | input | 1 | One-cycle pulse per bit time; line sampled on it |
| fifo_en | input | 1 | 1 selects FIFO mode |
| par_en | input | 1 | 1 enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd | input | 1 | Host read strobe, removes the shown word |
| clr_ovf | input | 1 | Host strobe clearing `ffovf` |
| err_ie | input | 1 | Receive-error interrupt enable |
| brk_ie | input | 1 | Break interrupt enable |
| rd_data | output | 16 | Oldest word with per-word error bits |
| rx_avail | output | 1 | A word is available |
| ferr | output | 1 | Sticky framing error |
| perr | output | 1 | Sticky parity error |
| oerr | output | 1 | Sticky overrun (holding register) |
| ffovf | output | 1 | Sticky FIFO overflow |
| brk | output | 1 | Sticky break detect |
| rx_err | output | 1 | Combined error flag |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to produce is a software reset inside the ten-bit break window. At that point the framing error is already set, but the break is not. The bench sends a frame with a low stop bit and holds the line low for five more bit times. It then pulses `sw_rst` and keeps the line low well beyond the point where the break would have risen, then checks that `brk` stays low. The same sequence shows that the stored framing bit of the low frame is still present after the reset. It also shows that a later clean frame is received once the line has gone high.

// File: rtl/uart_rx_errmon.sv
module uart_rx_errmon #(
  parameter int DEPTH    = 16,
  parameter int BRK_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst,
  input  logic        rx,
  input  logic        bit_tick,
  input  logic        fifo_en,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        rd,
  input  logic        clr_ovf,
  input  logic        err_ie,
  input  logic        brk_ie,
  output logic [15:0] rd_data,
  output logic        rx_avail,
  output logic        ferr,
  output logic        perr,
  output logic        oerr,
  output logic        ffovf,
  output logic        brk,
  output logic        rx_err,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(BRK_BITS);
  localparam logic [AW:0] FULLC = DEPTH[AW:0];

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_PAR, S_STOP, S_BRKW, S_HOLD} st_t;
  st_t st;
  logic [2:0]    idx;
  logic [BW-1:0] bc;
  logic [7:0]    sh;
  logic          pe_r, prev;

  logic [9:0]    mem [DEPTH];
  logic [AW:0]   wp, rp, cnt;
  logic [7:0]    hold_d;
  logic          hold_v;

  assign cnt = wp - rp;
  wire full   = (cnt == FULLC);
  wire empty  = (cnt == '0);
  wire push   = bit_tick && st == S_STOP && !sw_rst;
  wire push_f = push && fifo_en && !full;
  wire pop_f  = rd && fifo_en && !empty;
  wire push_h = push && !fifo_en && (!hold_v || rd);
  wire [9:0] head = mem[rp[AW-1:0]];

  assign rd_data  = fifo_en ? {head[9], head[8], 6'b0, head[7:0]} : {8'b0, hold_d};
  assign rx_avail = fifo_en ? !empty : hold_v;
  assign rx_err   = brk | ferr | oerr | perr;
  assign irq      = (err_ie & rx_err) | (brk_ie & brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; bc <= '0; sh <= '0; pe_r <= 1'b0; prev <= 1'b0;
      ferr <= 1'b0; perr <= 1'b0; oerr <= 1'b0; ffovf <= 1'b0; brk <= 1'b0;
    end else if (sw_rst) begin
      st <= S_IDLE; prev <= 1'b0;
      ferr <= 1'b0; perr <= 1'b0; oerr <= 1'b0; ffovf <= 1'b0; brk <= 1'b0;
    end else begin
      if (clr_ovf) ffovf <= 1'b0;
      if (bit_tick) begin
        case (st)
          S_IDLE: begin
            prev <= rx;
            if (prev && !rx) begin st <= S_DATA; idx <= '0; pe_r <= 1'b0; end
          end
          S_DATA: begin
            sh  <= {rx, sh[7:1]};
            idx <= idx + 3'd1;
            if (idx == 3'd7) st <= par_en ? S_PAR : S_STOP;
          end
          S_PAR: begin
            pe_r <= rx ^ (^sh) ^ par_odd;
            st   <= S_STOP;
          end
          S_STOP: begin
            if (pe_r) perr <= 1'b1;
            if (fifo_en && full) ffovf <= 1'b1;
            if (!fifo_en && hold_v && !rd) oerr <= 1'b1;
            if (!rx) begin ferr <= 1'b1; st <= S_BRKW; bc <= '0; end
            else begin st <= S_IDLE; prev <= 1'b1; end
          end
          S_BRKW: begin
            if (rx) begin st <= S_IDLE; prev <= 1'b1; end
            else if (bc == BW'(BRK_BITS - 1)) begin brk <= 1'b1; st <= S_HOLD; end
            else bc <= bc + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; hold_d <= '0; hold_v <= 1'b0;
    end else begin
      if (push_f) begin
        mem[wp[AW-1:0]] <= {!rx, pe_r, sh};
        wp <= wp + 1'b1;
      end
      if (pop_f) rp <= rp + 1'b1;
      if (push_h) begin hold_d <= sh; hold_v <= 1'b1; end
      else if (rd && !fifo_en) hold_v <= 1'b0;
    end
  end

  AST_BRK_AFTER_FE: assert property (@(posedge clk) disable iff (!rst_n) $rose(brk) |-> ferr); // R4
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sw_rst |=> !brk && !ferr && !perr && !oerr); // R5
  AST_FE_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) ferr && !sw_rst |=> ferr); // R3
  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
                      push && fifo_en && full && !rd |=> cnt == FULLC && ffovf); // R9
  AST_FIFO_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) sw_rst && !rd |=> $stable(cnt)); // R8
endmodule

// File: tb/sim_uart_rx_errmon.sv
module sim_uart_rx_errmon;
  logic clk = 0, rst_n = 0, sw_rst = 0, rx = 1, bit_tick = 0;
  logic fifo_en = 1, par_en = 1, par_odd = 0, rd = 0, clr_ovf = 0, err_ie = 0, brk_ie = 0;
  logic [15:0] rd_data;
  logic rx_avail, ferr, perr, oerr, ffovf, brk, rx_err, irq;
  int n_chk = 0, n_fail = 0;

  uart_rx_errmon u0 (.clk, .rst_n, .sw_rst, .rx, .bit_tick, .fifo_en, .par_en, .par_odd,
    .rd, .clr_ovf, .err_ie, .brk_ie, .rd_data, .rx_avail, .ferr, .perr, .oerr, .ffovf,
    .brk, .rx_err, .irq);

  always #10 clk = ~clk;

  // {data, bad_parity, bad_stop}
  localparam logic [9:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0}, {8'hFF, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1}, {8'h80, 1'b0, 1'b0}, {8'h6E, 1'b1, 1'b0}};

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b);
    @(negedge clk) rx = b; bit_tick = 1;
    @(negedge clk) bit_tick = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    bitx(1'b0);
    for (int i = 0; i < 8; i++) bitx(d[i]);
    if (par_en) bitx((^d) ^ par_odd ^ bad_par);
    bitx(!bad_stop);
  endtask

  task automatic pulse_sw;
    @(negedge clk) sw_rst = 1;
    @(negedge clk) sw_rst = 0;
  endtask

  task automatic do_rd;
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({ferr, perr, oerr, ffovf, brk, rx_err, irq, rx_avail} == 8'h00, "reset R6",
        {8'h0, ferr, perr, oerr, ffovf, brk, rx_err, irq, rx_avail}, 16'h0);
    bitx(1'b1);

    // Vector table: FIFO mode, even parity
    foreach (VEC[k]) begin
      logic [7:0] d; logic bp, bs;
      {d, bp, bs} = VEC[k];
      frame(d, bp, bs);
      if (bs) bitx(1'b1);
      chk(rd_data == {bs, bp, 6'b0, d}, "R1 R2 R3 R7 word", rd_data, {bs, bp, 6'b0, d});
      chk(ferr == bs && perr == bp, "R2 R3 flags", {14'b0, ferr, perr}, {14'b0, bs, bp});
      chk(rx_err == (bs | bp), "R6 rx_err", {15'b0, rx_err}, {15'b0, bs | bp});
      do_rd;
      pulse_sw;
      bitx(1'b1);
    end

    // Odd parity
    par_odd = 1;
    frame(8'h0F, 1'b0, 1'b0);
    chk(perr == 0 && rd_data == 16'h000F, "R2 odd good", rd_data, 16'h000F);
    do_rd;
    frame(8'h0F, 1'b1, 1'b0);
    chk(perr == 1 && rd_data == 16'h400F, "R2 odd bad", rd_data, 16'h400F);
    do_rd; pulse_sw; bitx(1'b1);
    par_odd = 0;

    // Break: low for ten further bits
    frame(8'h00, 1'b0, 1'b1);
    for (int i = 0; i < 9; i++) bitx(1'b0);
    chk(brk == 0 && ferr == 1, "R4 no brk at 9", {15'b0, brk}, 16'h0);
    chk(irq == 0, "R11 irq masked", {15'b0, irq}, 16'h0);
    bitx(1'b0);
    chk(brk == 1, "R4 brk at 10", {15'b0, brk}, 16'h1);
    brk_ie = 1; @(negedge clk);
    chk(irq == 1, "R11 brk irq", {15'b0, irq}, 16'h1);
    brk_ie = 0; err_ie = 1; @(negedge clk);
    chk(irq == 1, "R11 err irq", {15'b0, irq}, 16'h1);
    err_ie = 0;
    bitx(1'b1); bitx(1'b1);
    frame(8'h55, 1'b0, 1'b0);
    chk(rx_avail == 1 && rd_data == 16'h8000, "R4 hold ignores frame", rd_data, 16'h8000);
    do_rd;
    chk(rx_avail == 0, "R4 no extra word", {15'b0, rx_avail}, 16'h0);
    pulse_sw;
    chk(brk == 0 && ferr == 0, "R5 clears brk", {14'b0, brk, ferr}, 16'h0);
    bitx(1'b1);
    frame(8'h55, 1'b0, 1'b0);
    chk(rd_data == 16'h0055, "R5 resumes", rd_data, 16'h0055);
    do_rd;

    // Software reset mid-break
    frame(8'h00, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) bitx(1'b0);
    pulse_sw;
    for (int i = 0; i < 8; i++) bitx(1'b0);
    chk(brk == 0 && ferr == 0, "R5 break cancelled", {14'b0, brk, ferr}, 16'h0);
    chk(rd_data == 16'h8000 && rx_avail, "R8 per-word fe kept", rd_data, 16'h8000);
    do_rd;
    bitx(1'b1);
    frame(8'hC3, 1'b0, 1'b0);
    chk(rd_data == 16'h00C3, "R5 frame after cancel", rd_data, 16'h00C3);
    do_rd;

    // Per-word parity bit survives sw_rst
    frame(8'h12, 1'b1, 1'b0);
    pulse_sw;
    chk(rd_data == 16'h4012 && perr == 0, "R8 per-word pe kept", rd_data, 16'h4012);
    do_rd; bitx(1'b1);

    // FIFO overflow
    for (int i = 0; i < 17; i++) frame(8'(i + 8'h20), 1'b0, 1'b0);
    chk(ffovf == 1, "R9 ffovf set", {15'b0, ffovf}, 16'h1);
    for (int i = 0; i < 16; i++) begin
      chk(rd_data == {8'h00, 8'(i + 8'h20)}, "R7 R9 order", rd_data, {8'h00, 8'(i + 8'h20)});
      do_rd;
    end
    chk(rx_avail == 0, "R9 17th dropped", {15'b0, rx_avail}, 16'h0);
    @(negedge clk) clr_ovf = 1;
    @(negedge clk) clr_ovf = 0;
    chk(ffovf == 0, "R9 clr_ovf", {15'b0, ffovf}, 16'h0);

    // Non-FIFO mode
    fifo_en = 0;
    frame(8'h9A, 1'b0, 1'b0);
    frame(8'h77, 1'b1, 1'b0);
    chk(oerr == 1 && rd_data == 16'h009A, "R10 overrun keeps old", rd_data, 16'h009A);
    chk(perr == 1 && rx_err == 1, "R10 perr in non-FIFO", {14'b0, perr, rx_err}, 16'h3);
    err_ie = 1; @(negedge clk);
    chk(irq == 1, "R11 oerr irq", {15'b0, irq}, 16'h1);
    do_rd;
    chk(rx_avail == 0, "R10 read empties", {15'b0, rx_avail}, 16'h0);
    err_ie = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule